// File: doc/BRIEF.md
# TDM Multichannel Element Selector

This block follows the position inside a single-phase time-division-multiplexed frame of up to 128 elements. It decides, element by element, whether the current element takes part in reception and in transmission. A serial shifter sits beside it. The shifter pulses an element-boundary strobe and a frame-start strobe, and it reads back the current channel number together with three flags:

- a receive enable, which gates the ready flag, the buffer copy and the event for that element;
- a transmit enable;
- a transmit high-impedance flag, which tells the shifter to release the data line for the element.

Channels are chosen in one of two ways:

- **Partitioned mode.** Two 16-bit enable fields each act on one 16-channel block. The first field picks its block from the even blocks and the second from the odd blocks. At most 32 channels can be live at once.
- **Enhanced mode.** A 128-bit enable map turns each channel on or off one by one.

The transmit side has four policies: everything on, selected by its own map, always enabled but masked by its own map, or symmetric. In symmetric mode the receive map decides which channels are enabled and the transmit map decides which of them are unmasked. When the frame is flagged as multi-phase, selection is bypassed and every element is enabled.

Top module: `tdm_chan_sel`

## Requirements
- R1: While `rst_n` is low the channel counter is 0 after the next clock edge.
- R2: A cycle with `frame_start` high makes `chan` equal 0 after that edge, whatever `elem_strobe` is.
- R3: With `frame_start` low, `elem_strobe` high advances `chan` by one (127 wraps to 0); with both low `chan` holds.
- R4: Partitioned mode (`enh_mode`=0): block k = `chan`[6:4]; odd k belongs to the second partition, even k to the first, sub-index `chan`[6:5]. The element is enabled when the sub-index equals the block number selected for its partition and bit `chan`[3:0] of the map is set (first partition uses map bits 15:0, second uses 31:16).
- R5: In partitioned mode no element outside the two selected blocks is enabled, so at most 32 of 128 are.
- R6: Enhanced mode (`enh_mode`=1): channel c is enabled exactly when map bit c is set, e.g. channel 80 uses bit 80 (bit 16 of the third 32-bit word).
- R7: With `rx_sel_on`=0 every element is receive-enabled.
- R8: `tx_mode`=0: `tx_en`=1 and `tx_hiz`=0 for every element.
- R9: `tx_mode`=1: `tx_en` follows the transmit map decode (R4/R6 rules, transmit blocks) and `tx_hiz` = not `tx_en`.
- R10: `tx_mode`=2: `tx_en`=1 and `tx_hiz` is set when the transmit map decode is 0.
- R11: `tx_mode`=3 (symmetric): `tx_en` is the receive map decode with the receive blocks; `tx_hiz` is set unless both that and the transmit map decode (transmit blocks) are 1.
- R12: With `multi_phase`=1, `rx_en`=1, `tx_en`=1 and `tx_hiz`=0 regardless of all other settings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| frame_start | input | 1 | Frame start strobe, clears the counter |
| elem_strobe | input | 1 | Element boundary strobe, advances the counter |
| multi_phase | input | 1 | Frame is multi-phase; selection bypassed |
| enh_mode | input | 1 | 1 = per-channel map, 0 = partitioned |
| rx_sel_on | input | 1 | Receive selection active |
| tx_mode | input | 2 | Transmit policy 0..3 |
| rx_blk_a | input | 2 | Receive block for the even-block partition |
| rx_blk_b | input | 2 | Receive block for the odd-block partition |
| tx_blk_a | input | 2 | Transmit block for the even-block partition |
| tx_blk_b | input | 2 | Transmit block for the odd-block partition |
| rx_map | input | 128 | Receive enable map |
| tx_map | input | 128 | Transmit enable/unmask map |
| chan | output | 7 | Current channel number |
| rx_en | output | 1 | Current element is receive-enabled |
| tx_en | output | 1 | Current element is transmit-enabled |
| tx_hiz | output | 1 | Data line released for current element |

## Verification
The hardest case to reach is a partitioned-mode frame in which the counter walks across every one of the eight blocks while several differing block selections are applied. The same holds for symmetric mode, where a channel is enabled by one map and masked by the other. The stimulus sweeps all 32 combinations of the mode inputs. For each combination it loads fresh random maps and block numbers, then drives long runs of boundary strobes with occasional frame starts, some of them in the same cycle as a strobe. A directed pass sets a single map bit at channel 80 in enhanced mode and steps the counter up to that channel.

// File: rtl/tdm_sel_pkg.sv
// Shared definitions for the TDM element selector.
// Assumes a 2-bit transmit policy field as listed below.
package tdm_sel_pkg;
    typedef enum logic [1:0] {
        TXM_ALL  = 2'd0,
        TXM_SEL  = 2'd1,
        TXM_MASK = 2'd2,
        TXM_SYM  = 2'd3
    } tx_mode_e;
endpackage

// File: rtl/tdm_chan_count.sv
// Element index counter. It clears on frame start, and frame start takes
// priority over a boundary strobe. On a strobe it advances and wraps
// modulo 2**CH_W. Assumes at most one boundary per clock.
module tdm_chan_count #(
    parameter int CH_W = 7
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            frame_start,
    input  logic            elem_strobe,
    output logic [CH_W-1:0] chan
);
    // Track the element position inside the frame.
    always_ff @(posedge clk) begin
        if (!rst_n)
            chan <= '0;
        else if (frame_start)
            chan <= '0;
        else if (elem_strobe)
            chan <= chan + 1'b1;
    end
endmodule

// File: rtl/tdm_chan_decode.sv
// Enable decoder for one map. In enhanced mode it indexes the map by the
// channel number. In partitioned mode it picks the partition from the low
// block bit and the sub-block from the upper bits, then indexes the
// partition's field. Assumes NUM_CHAN >= 2*PART_W, both powers of two.
module tdm_chan_decode #(
    parameter int NUM_CHAN = 128,
    parameter int PART_W   = 16,
    localparam int CH_W    = $clog2(NUM_CHAN),
    localparam int OFS_W   = $clog2(PART_W),
    localparam int SUB_W   = CH_W - OFS_W - 1
) (
    input  logic [CH_W-1:0]     chan,
    input  logic [NUM_CHAN-1:0] map,
    input  logic [SUB_W-1:0]    blk_a,
    input  logic [SUB_W-1:0]    blk_b,
    input  logic                enh,
    output logic                hit
);
    logic [SUB_W-1:0] sub;
    logic             part_b;
    logic [OFS_W:0]   fld_idx;
    logic             blk_match;

    // Split the channel into sub-block, partition and field index.
    always_comb begin
        sub       = chan[CH_W-1:OFS_W+1];
        part_b    = chan[OFS_W];
        fld_idx   = {part_b, chan[OFS_W-1:0]};
        blk_match = part_b ? (sub == blk_b) : (sub == blk_a);
    end

    // Pick the enable source for the active mode.
    always_comb begin
        if (enh)
            hit = map[chan];
        else
            hit = blk_match & map[fld_idx];
    end
endmodule

// File: rtl/tdm_chan_sel.sv
// TDM multichannel element selector, top level. It runs the element
// counter and decodes the receive and transmit maps. The transmit policy
// then turns those decodes into the enable and high-impedance flags.
// Outputs are combinational from the registered channel and the
// configuration. Assumes the configuration is steady within a frame.
module tdm_chan_sel
    import tdm_sel_pkg::*;
#(
    parameter int NUM_CHAN = 128,
    parameter int PART_W   = 16,
    localparam int CH_W    = $clog2(NUM_CHAN),
    localparam int SUB_W   = CH_W - $clog2(PART_W) - 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                frame_start,
    input  logic                elem_strobe,
    input  logic                multi_phase,
    input  logic                enh_mode,
    input  logic                rx_sel_on,
    input  logic [1:0]          tx_mode,
    input  logic [SUB_W-1:0]    rx_blk_a,
    input  logic [SUB_W-1:0]    rx_blk_b,
    input  logic [SUB_W-1:0]    tx_blk_a,
    input  logic [SUB_W-1:0]    tx_blk_b,
    input  logic [NUM_CHAN-1:0] rx_map,
    input  logic [NUM_CHAN-1:0] tx_map,
    output logic [CH_W-1:0]     chan,
    output logic                rx_en,
    output logic                tx_en,
    output logic                tx_hiz
);
    logic     rx_hit;
    logic     tx_hit;
    tx_mode_e mode;

    tdm_chan_count #(.CH_W(CH_W)) u_cnt (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_start (frame_start),
        .elem_strobe (elem_strobe),
        .chan        (chan)
    );

    tdm_chan_decode #(.NUM_CHAN(NUM_CHAN), .PART_W(PART_W)) u_rx_dec (
        .chan  (chan),
        .map   (rx_map),
        .blk_a (rx_blk_a),
        .blk_b (rx_blk_b),
        .enh   (enh_mode),
        .hit   (rx_hit)
    );

    tdm_chan_decode #(.NUM_CHAN(NUM_CHAN), .PART_W(PART_W)) u_tx_dec (
        .chan  (chan),
        .map   (tx_map),
        .blk_a (tx_blk_a),
        .blk_b (tx_blk_b),
        .enh   (enh_mode),
        .hit   (tx_hit)
    );

    // Receive enable: bypassed for multi-phase frames or when selection is off.
    always_comb begin
        rx_en = multi_phase | ~rx_sel_on | rx_hit;
    end

    // Transmit policy: enable and mask per element.
    always_comb begin
        mode = tx_mode_e'(tx_mode);
        if (multi_phase) begin
            tx_en  = 1'b1;
            tx_hiz = 1'b0;
        end else begin
            unique case (mode)
                TXM_ALL: begin
                    tx_en  = 1'b1;
                    tx_hiz = 1'b0;
                end
                TXM_SEL: begin
                    tx_en  = tx_hit;
                    tx_hiz = ~tx_hit;
                end
                TXM_MASK: begin
                    tx_en  = 1'b1;
                    tx_hiz = ~tx_hit;
                end
                default: begin
                    tx_en  = rx_hit;
                    tx_hiz = ~(rx_hit & tx_hit);
                end
            endcase
        end
    end
endmodule

// File: rtl/tdm_sel_chk.sv
// Property checker for tdm_chan_sel, attached with bind. It only observes
// the ports and assumes 128 channels in 16-channel blocks.
module tdm_sel_chk #(
    parameter int CH_W = 7
) (
    input logic            clk,
    input logic            rst_n,
    input logic            frame_start,
    input logic            elem_strobe,
    input logic            multi_phase,
    input logic            enh_mode,
    input logic            rx_sel_on,
    input logic [1:0]      tx_mode,
    input logic [1:0]      rx_blk_a,
    input logic [1:0]      rx_blk_b,
    input logic [CH_W-1:0] chan,
    input logic            rx_en,
    input logic            tx_en,
    input logic            tx_hiz
);
    assert_frame_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> (chan == '0));

    assert_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (elem_strobe && !frame_start) |=> (chan == CH_W'($past(chan) + 1'b1)));

    assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!elem_strobe && !frame_start) |=> $stable(chan));

    assert_block_limit_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!enh_mode && rx_sel_on && !multi_phase && rx_en) |->
        (chan[4] ? (chan[6:5] == rx_blk_b) : (chan[6:5] == rx_blk_a)));

    assert_rx_bypass_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!rx_sel_on) |-> rx_en);

    assert_tx_all_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_mode == 2'd0) |-> (tx_en && !tx_hiz));

    assert_tx_sel_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_mode == 2'd1 && !multi_phase) |-> (tx_hiz == !tx_en));

    assert_disabled_hiz_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_en) |-> tx_hiz);

    assert_multi_phase_R12: assert property (@(posedge clk) disable iff (!rst_n)
        multi_phase |-> (rx_en && tx_en && !tx_hiz));
endmodule

bind tdm_chan_sel tdm_sel_chk #(.CH_W(7)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .frame_start (frame_start),
    .elem_strobe (elem_strobe),
    .multi_phase (multi_phase),
    .enh_mode    (enh_mode),
    .rx_sel_on   (rx_sel_on),
    .tx_mode     (tx_mode),
    .rx_blk_a    (rx_blk_a),
    .rx_blk_b    (rx_blk_b),
    .chan        (chan),
    .rx_en       (rx_en),
    .tx_en       (tx_en),
    .tx_hiz      (tx_hiz)
);

// File: tb/sim_tdm_chan_sel.sv
module sim_tdm_chan_sel;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         frame_start = 1'b0;
    logic         elem_strobe = 1'b0;
    logic         multi_phase = 1'b0;
    logic         enh_mode = 1'b0;
    logic         rx_sel_on = 1'b0;
    logic [1:0]   tx_mode = 2'd0;
    logic [1:0]   rx_blk_a = 2'd0, rx_blk_b = 2'd0, tx_blk_a = 2'd0, tx_blk_b = 2'd0;
    logic [127:0] rx_map = '0, tx_map = '0;
    logic [6:0]   chan;
    logic         rx_en, tx_en, tx_hiz;

    int checks = 0;
    int errors = 0;
    int ref_chan = 0;
    int cycles = 0;

    always #5 clk = ~clk;

    tdm_chan_sel u0 (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .elem_strobe(elem_strobe),
        .multi_phase(multi_phase), .enh_mode(enh_mode), .rx_sel_on(rx_sel_on),
        .tx_mode(tx_mode), .rx_blk_a(rx_blk_a), .rx_blk_b(rx_blk_b),
        .tx_blk_a(tx_blk_a), .tx_blk_b(tx_blk_b), .rx_map(rx_map), .tx_map(tx_map),
        .chan(chan), .rx_en(rx_en), .tx_en(tx_en), .tx_hiz(tx_hiz)
    );

    // Reference counter, behavioural.
    always @(posedge clk) begin
        cycles++;
        if (!rst_n) ref_chan = 0;
        else if (frame_start) ref_chan = 0;
        else if (elem_strobe) ref_chan = (ref_chan + 1) % 128;
    end

    // Watchdog: counts as a failure and still prints the summary.
    always @(posedge clk) begin
        if (cycles > 150000) begin
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected under 150000", cycles);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    function automatic bit ref_dec(input logic [127:0] m, input int ba, input int bb,
                                   input bit enh, input int ch);
        int blk, off;
        if (enh) return m[ch];
        blk = ch / 16;
        off = ch % 16;
        if (blk % 2 == 0) return (blk / 2 == ba) && m[off];
        return (blk / 2 == bb) && m[16 + off];
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: chan %0d actual %0d expected %0d", tag, ref_chan, act, exp);
        end
    endtask

    // Sample at the falling edge and compare every output with the model.
    task automatic cyc();
        bit rh, th, e_rx, e_tx, e_hz;
        string rtag, ttag;
        @(negedge clk);
        chk("R3 chan", int'(chan), ref_chan);
        rh = ref_dec(rx_map, rx_blk_a, rx_blk_b, enh_mode, ref_chan);
        th = ref_dec(tx_map, tx_blk_a, tx_blk_b, enh_mode, ref_chan);
        if (multi_phase) begin
            e_rx = 1; rtag = "R12 rx_en";
        end else if (!rx_sel_on) begin
            e_rx = 1; rtag = "R7 rx_en";
        end else begin
            e_rx = rh;
            rtag = enh_mode ? "R6 rx_en" : (rh ? "R4 rx_en" : "R5 rx_en");
        end
        chk(rtag, rx_en, e_rx);
        if (multi_phase) begin
            e_tx = 1; e_hz = 0; ttag = "R12 tx";
        end else case (tx_mode)
            2'd0: begin e_tx = 1;  e_hz = 0;          ttag = "R8 tx"; end
            2'd1: begin e_tx = th; e_hz = !th;        ttag = "R9 tx"; end
            2'd2: begin e_tx = 1;  e_hz = !th;        ttag = "R10 tx"; end
            default: begin e_tx = rh; e_hz = !(rh && th); ttag = "R11 tx"; end
        endcase
        chk({ttag, "_en"}, tx_en, e_tx);
        chk({ttag, "_hiz"}, tx_hiz, e_hz);
    endtask

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        chk("R1 chan after reset", int'(chan), 0);
        rst_n = 1'b1;
        cyc();

        // Directed: enhanced mode, only channel 80 set (R6).
        enh_mode = 1; rx_sel_on = 1; tx_mode = 2'd1;
        rx_map = '0; rx_map[80] = 1'b1; tx_map = rx_map;
        frame_start = 1; cyc(); frame_start = 0;
        elem_strobe = 1;
        for (int i = 0; i < 82; i++) begin
            cyc();
            if (ref_chan == 80) chk("R6 channel 80 enabled", rx_en, 1);
        end
        // R2: frame start together with a strobe clears.
        frame_start = 1; cyc(); frame_start = 0; elem_strobe = 0;
        cyc();
        chk("R2 clear with strobe", int'(chan), 0);

        // Sweep all mode combinations with random maps.
        for (int cfg = 0; cfg < 32; cfg++) begin
            enh_mode = cfg[0]; tx_mode = 2'(cfg >> 1); rx_sel_on = cfg[3]; multi_phase = cfg[4];
            rx_map = {$urandom, $urandom, $urandom, $urandom};
            tx_map = {$urandom, $urandom, $urandom, $urandom};
            rx_blk_a = 2'($urandom); rx_blk_b = 2'($urandom);
            tx_blk_a = 2'($urandom); tx_blk_b = 2'($urandom);
            frame_start = 1; elem_strobe = 0; cyc(); frame_start = 0;
            for (int i = 0; i < 320; i++) begin
                elem_strobe = ($urandom % 4) != 0;
                frame_start = ($urandom % 150) == 0;
                cyc();
            end
            frame_start = 0; elem_strobe = 0;
        end

        // Wrap 127 -> 0 (R3).
        multi_phase = 0; frame_start = 1; cyc(); frame_start = 0; elem_strobe = 1;
        for (int i = 0; i < 128; i++) cyc();
        chk("R3 wrap to zero", int'(chan), 0);
        elem_strobe = 0; cyc();

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule